// File: doc/BRIEF.md
# Smart Card Activation and Answer-to-Reset Sequencer

This block brings a smart card up and down in a fixed order and times the card's answer to reset. A command write sets or clears a start bit. Setting it powers the card, enables the card clock and I/O path after a short delay, and runs a cold reset. Clearing it, or raising the forced-off input, runs the steps in reverse. After each reset release the block counts card clock ticks. It watches the card I/O line for the first falling edge, which marks the start of the answer.

If the cold window closes with no answer, the card stays powered with its reset line high. Software may then request one warm reset, which opens a second window of the same length. A one-cycle mute pulse is raised only when the warm window also closes with no answer. A separate one-cycle early pulse marks an answer that begins too soon after reset release. Supply voltage selection and the analog rails sit outside this block, which only drives their enables.

Top module: `card_act_seq`

## Requirements
- R1: After reset the start bit is 0 and every output is low; the card stays off until start is written to 1.
- R2: Writing start=1 while off raises `pwr_en_o` on the next cycle. `clk_en_o` and `io_en_o` rise exactly SEQ_DLY cycles after `pwr_en_o`, with the reset line held low.
- R3: The reset line (`card_rst_o`, 1 = released) stays low for RST_LOW card clock ticks after the clock is enabled, then goes high.
- R4: While a window is open, the answer is the first falling edge of `card_io_i` after a two-stage synchronizer. It ends the window and the reset line stays high. Later edges on the line produce no pulse.
- R5: An answer whose tick count since reset release lies between EARLY_LO and EARLY_HI (inclusive, default 200 and 352) gives a one-cycle `early_o` pulse. An answer outside that range gives none.
- R6: If no answer arrives within WIN_CYC ticks (default 45000) of cold reset release, the card stays powered with reset high and no mute pulse is raised.
- R7: A write with the warm bit set is acted on only after the cold window has expired with no answer. It drives reset low for RST_LOW ticks, then releases it and opens a new WIN_CYC window. In any other state the request is ignored.
- R8: If the warm window also expires with no answer, `mute_o` pulses for one cycle and the card stays powered.
- R9: Writing start=0 while the card is up drives reset low on the next cycle. The clock and I/O enables drop SEQ_DLY cycles later, and power drops SEQ_DLY cycles after that.
- R10: `force_off_i` starts the deactivation on the next cycle from any active state. It clears the start bit and takes priority over a write in the same cycle, so the card does not come back up until start is written again.
- R11: If the answer edge falls in the same cycle in which a window would expire, the answer wins: no mute pulse, and the card stays in session.
- R12: The window and reset-hold counts advance only on cycles where `clk_tick_i` is high. With no ticks, nothing times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_start_i | input | 1 | Start bit value written on a strobe |
| cmd_warm_i | input | 1 | Warm-reset request carried on a strobe |
| force_off_i | input | 1 | Forced deactivation request |
| clk_tick_i | input | 1 | One-cycle enable per card clock period |
| card_io_i | input | 1 | Card I/O line, asynchronous |
| pwr_en_o | output | 1 | Card supply enable |
| clk_en_o | output | 1 | Card clock enable |
| io_en_o | output | 1 | Card I/O path enable |
| card_rst_o | output | 1 | Card reset line, 0 = held in reset |
| mute_o | output | 1 | One-cycle pulse: no answer after both windows |
| early_o | output | 1 | One-cycle pulse: answer inside the early range |

## Verification
The collision that matters is an answer edge arriving in the very cycle in which the warm window times out. The bench triggers it by counting from the observed reset release and pulling the I/O line low three synchronizer stages ahead of that last tick. A correct design must then show no mute pulse and keep the reset line high. A cold-window warm request and a tick stall are also placed inside open windows, to show that neither shortens the count.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PWR_UP,
    ST_COLD_RST,
    ST_COLD_WAIT,
    ST_COLD_IDLE,
    ST_WARM_RST,
    ST_WARM_WAIT,
    ST_SESSION,
    ST_MUTE_IDLE,
    ST_DN_RST,
    ST_DN_CLK
  } seq_state_e;

  function automatic logic st_clk_on(seq_state_e s);
    return s inside {ST_COLD_RST, ST_COLD_WAIT, ST_COLD_IDLE, ST_WARM_RST,
                     ST_WARM_WAIT, ST_SESSION, ST_MUTE_IDLE, ST_DN_RST};
  endfunction

  function automatic logic st_rst_high(seq_state_e s);
    return s inside {ST_COLD_WAIT, ST_COLD_IDLE, ST_WARM_WAIT, ST_SESSION,
                     ST_MUTE_IDLE};
  endfunction

  // counter advances every system cycle in these states
  function automatic logic st_sys_timed(seq_state_e s);
    return s inside {ST_PWR_UP, ST_DN_RST, ST_DN_CLK};
  endfunction

  // counter advances on card clock ticks in these states
  function automatic logic st_tick_timed(seq_state_e s);
    return s inside {ST_COLD_RST, ST_COLD_WAIT, ST_WARM_RST, ST_WARM_WAIT};
  endfunction

endpackage

// File: rtl/card_io_edge.sv
module card_io_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_i,
  output logic fall_o
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  // idle line is high; reset the chain high so no edge appears at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[CHAIN_W-2:0], io_i};
  end

  assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

endmodule

// File: rtl/card_seq_timer.sv
module card_seq_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/card_seq_cmd.sv
module card_seq_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic start_bit_i,
  input  logic warm_bit_i,
  input  logic force_i,
  output logic start_o,
  output logic warm_req_o
);

  logic start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      start_q <= 1'b0;
    else if (force_i) start_q <= 1'b0;
    else if (wr_i)    start_q <= start_bit_i;
  end

  assign start_o    = start_q;
  assign warm_req_o = wr_i & warm_bit_i & ~force_i;

  // R10
  force_clears_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> !start_o);

endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
  import card_seq_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 45000,
  parameter int unsigned RST_LOW  = 400,
  parameter int unsigned SEQ_DLY  = 4,
  parameter int unsigned EARLY_LO = 200,
  parameter int unsigned EARLY_HI = 352,
  parameter int unsigned CW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          warm_req_i,
  input  logic          force_i,
  input  logic          tick_i,
  input  logic          fall_i,
  input  logic [CW-1:0] cnt_i,
  output logic          timer_clr_o,
  output logic          timer_inc_o,
  output logic          pwr_en_o,
  output logic          clk_en_o,
  output logic          card_rst_o,
  output logic          mute_o,
  output logic          early_o
);

  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_LOW - 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(SEQ_DLY - 1);
  localparam logic [CW-1:0] ERL_LO   = CW'(EARLY_LO);
  localparam logic [CW-1:0] ERL_HI   = CW'(EARLY_HI);

  seq_state_e state_q, state_d;
  logic       mute_q, mute_d;
  logic       early_q, early_d;
  logic       go_down, dly_done, rst_done, win_done, in_early;

  assign go_down  = force_i | ~start_i;
  assign dly_done = (cnt_i == DLY_LAST);
  assign rst_done = tick_i & (cnt_i == RST_LAST);
  assign win_done = tick_i & (cnt_i == WIN_LAST);
  assign in_early = (cnt_i >= ERL_LO) & (cnt_i <= ERL_HI);

  always_comb begin
    state_d = state_q;
    mute_d  = 1'b0;
    early_d = 1'b0;
    unique case (state_q)
      ST_OFF:       if (start_i && !force_i) state_d = ST_PWR_UP;
      ST_PWR_UP:    if (go_down)        state_d = ST_DN_RST;
                    else if (dly_done)  state_d = ST_COLD_RST;
      ST_COLD_RST:  if (go_down)        state_d = ST_DN_RST;
                    else if (rst_done)  state_d = ST_COLD_WAIT;
      ST_COLD_WAIT: if (go_down)        state_d = ST_DN_RST;
                    else if (fall_i) begin
                      state_d = ST_SESSION;
                      early_d = in_early;
                    end
                    else if (win_done)  state_d = ST_COLD_IDLE;
      ST_COLD_IDLE: if (go_down)        state_d = ST_DN_RST;
                    else if (warm_req_i) state_d = ST_WARM_RST;
      ST_WARM_RST:  if (go_down)        state_d = ST_DN_RST;
                    else if (rst_done)  state_d = ST_WARM_WAIT;
      ST_WARM_WAIT: if (go_down)        state_d = ST_DN_RST;
                    else if (fall_i) begin
                      state_d = ST_SESSION;
                      early_d = in_early;
                    end
                    else if (win_done) begin
                      state_d = ST_MUTE_IDLE;
                      mute_d  = 1'b1;
                    end
      ST_SESSION,
      ST_MUTE_IDLE: if (go_down)        state_d = ST_DN_RST;
      ST_DN_RST:    if (dly_done)       state_d = ST_DN_CLK;
      ST_DN_CLK:    if (dly_done)       state_d = ST_OFF;
      default:                          state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      mute_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mute_q  <= mute_d;
      early_q <= early_d;
    end
  end

  assign timer_clr_o = (state_d != state_q);
  assign timer_inc_o = st_sys_timed(state_q) | (st_tick_timed(state_q) & tick_i);

  assign pwr_en_o   = (state_q != ST_OFF);
  assign clk_en_o   = st_clk_on(state_q);
  assign card_rst_o = st_rst_high(state_q);
  assign mute_o     = mute_q;
  assign early_o    = early_q;

  // R2
  pwr_before_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> $past(pwr_en_o));

  // R3
  clk_before_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_rst_o) |-> $past(clk_en_o));

  // R3
  timer_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> (cnt_i == '0));

  // R9
  pwr_off_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> !$past(clk_en_o));

  // R8
  mute_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |=> !mute_o);

  // R5
  early_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |=> !early_o);

  // R10
  force_rst_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> !card_rst_o);

  // R12
  tick_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && st_tick_timed(state_q) && (state_d == state_q)) |=> $stable(cnt_i));

endmodule

// File: rtl/card_act_seq.sv
module card_act_seq #(
  parameter int unsigned WIN_CYC     = 45000,
  parameter int unsigned RST_LOW     = 400,
  parameter int unsigned SEQ_DLY     = 4,
  parameter int unsigned EARLY_LO    = 200,
  parameter int unsigned EARLY_HI    = 352,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_wr_i,
  input  logic cmd_start_i,
  input  logic cmd_warm_i,
  input  logic force_off_i,
  input  logic clk_tick_i,
  input  logic card_io_i,
  output logic pwr_en_o,
  output logic clk_en_o,
  output logic io_en_o,
  output logic card_rst_o,
  output logic mute_o,
  output logic early_o
);

  localparam int unsigned MAX_A = (WIN_CYC > RST_LOW) ? WIN_CYC : RST_LOW;
  localparam int unsigned MAX_C = (MAX_A > SEQ_DLY) ? MAX_A : SEQ_DLY;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  logic          start_q, warm_req, fall;
  logic          t_clr, t_inc;
  logic [CW-1:0] t_cnt;
  logic          clk_on;

  card_seq_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (cmd_wr_i),
    .start_bit_i (cmd_start_i),
    .warm_bit_i  (cmd_warm_i),
    .force_i     (force_off_i),
    .start_o     (start_q),
    .warm_req_o  (warm_req)
  );

  card_io_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .io_i   (card_io_i),
    .fall_o (fall)
  );

  card_seq_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (t_clr),
    .inc_i  (t_inc),
    .cnt_o  (t_cnt)
  );

  card_seq_fsm #(
    .WIN_CYC  (WIN_CYC),
    .RST_LOW  (RST_LOW),
    .SEQ_DLY  (SEQ_DLY),
    .EARLY_LO (EARLY_LO),
    .EARLY_HI (EARLY_HI),
    .CW       (CW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_q),
    .warm_req_i  (warm_req),
    .force_i     (force_off_i),
    .tick_i      (clk_tick_i),
    .fall_i      (fall),
    .cnt_i       (t_cnt),
    .timer_clr_o (t_clr),
    .timer_inc_o (t_inc),
    .pwr_en_o    (pwr_en_o),
    .clk_en_o    (clk_on),
    .card_rst_o  (card_rst_o),
    .mute_o      (mute_o),
    .early_o     (early_o)
  );

  assign clk_en_o = clk_on;
  assign io_en_o  = clk_on;

endmodule

// File: tb/sim_card_act_seq.sv
`timescale 1ns/1ps
module sim_card_act_seq;

  localparam int WIN = 600;
  localparam int RLO = 50;
  localparam int DLY = 4;
  localparam int ELO = 200;
  localparam int EHI = 352;

  // model state codes
  localparam int M_OFF = 0, M_PWR = 1, M_CRST = 2, M_CWAIT = 3, M_CIDLE = 4,
                 M_WRST = 5, M_WWAIT = 6, M_SESS = 7, M_MIDLE = 8,
                 M_DRST = 9, M_DCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0, start_bit = 1'b0, warm_bit = 1'b0;
  logic force_off = 1'b0, tick = 1'b0, io = 1'b1;
  logic pwr, clk_en, io_en, card_rst, mute, early;

  int errors = 0, checks = 0, cyc = 0;
  int tick_mode = 1, tick_ph = 0;
  int mute_cnt = 0, early_cnt = 0;

  always #4 clk = ~clk;

  card_act_seq #(.WIN_CYC(WIN), .RST_LOW(RLO), .SEQ_DLY(DLY),
                 .EARLY_LO(ELO), .EARLY_HI(EHI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_start_i(start_bit),
    .cmd_warm_i(warm_bit), .force_off_i(force_off), .clk_tick_i(tick),
    .card_io_i(io), .pwr_en_o(pwr), .clk_en_o(clk_en), .io_en_o(io_en),
    .card_rst_o(card_rst), .mute_o(mute), .early_o(early));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  int m_st = M_OFF, m_cnt = 0;
  bit m_start = 0, m_mute = 0, m_early = 0;
  bit io_hist[$] = '{1'b1, 1'b1, 1'b1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_OFF; m_cnt = 0; m_start = 0; m_mute = 0; m_early = 0;
      io_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit fall, down, wreq, inc;
      int nst;
      bit nm, ne;
      fall = io_hist[0] && !io_hist[1];
      down = force_off || !m_start;
      wreq = cmd_wr && warm_bit && !force_off;
      nst = m_st; nm = 0; ne = 0;
      case (m_st)
        M_OFF:  if (m_start && !force_off) nst = M_PWR;
        M_PWR:  if (down) nst = M_DRST; else if (m_cnt == DLY-1) nst = M_CRST;
        M_CRST, M_WRST:
          if (down) nst = M_DRST;
          else if (tick && m_cnt == RLO-1) nst = (m_st == M_CRST) ? M_CWAIT : M_WWAIT;
        M_CWAIT, M_WWAIT:
          if (down) nst = M_DRST;
          else if (fall) begin nst = M_SESS; ne = (m_cnt >= ELO && m_cnt <= EHI); end
          else if (tick && m_cnt == WIN-1) begin
            if (m_st == M_CWAIT) nst = M_CIDLE;
            else begin nst = M_MIDLE; nm = 1; end
          end
        M_CIDLE: if (down) nst = M_DRST; else if (wreq) nst = M_WRST;
        M_SESS, M_MIDLE: if (down) nst = M_DRST;
        M_DRST: if (m_cnt == DLY-1) nst = M_DCLK;
        M_DCLK: if (m_cnt == DLY-1) nst = M_OFF;
        default: nst = M_OFF;
      endcase
      inc = (m_st == M_PWR || m_st == M_DRST || m_st == M_DCLK) ||
            ((m_st == M_CRST || m_st == M_CWAIT || m_st == M_WRST || m_st == M_WWAIT) && tick);
      if (nst != m_st) m_cnt = 0; else if (inc) m_cnt = m_cnt + 1;
      m_st = nst; m_mute = nm; m_early = ne;
      if (force_off) m_start = 0; else if (cmd_wr) m_start = start_bit;
      void'(io_hist.pop_front());
      io_hist.push_back(io);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (mute) mute_cnt++;
    if (early) early_cnt++;
    if (rst_n) begin
      bit e_clk, e_rst;
      e_clk = (m_st >= M_CRST && m_st <= M_DRST);
      e_rst = (m_st == M_CWAIT || m_st == M_CIDLE || m_st == M_WWAIT ||
               m_st == M_SESS || m_st == M_MIDLE);
      chk("R2 R9 pwr_en model", pwr, m_st != M_OFF);
      chk("R2 R9 clk_en model", clk_en, e_clk);
      chk("R2 io_en model", io_en, e_clk);
      chk("R3 R4 card_rst model", card_rst, e_rst);
      chk("R8 R11 mute model", mute, m_mute);
      chk("R5 early model", early, m_early);
    end
    if (tick_mode == 1) tick <= 1'b1;
    else if (tick_mode == 2) begin tick_ph++; tick <= tick_ph[0]; end
    else tick <= 1'b0;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic write_cmd(bit s, bit w);
    @(negedge clk); cmd_wr = 1; start_bit = s; warm_bit = w;
    @(negedge clk); cmd_wr = 0; warm_bit = 0;
  endtask

  task automatic wait_rst_high();
    while (!card_rst) @(negedge clk);
  endtask

  task automatic wait_off();
    while (pwr) @(negedge clk);
  endtask

  initial begin
    int n, m0, e0;
    repeat (3) @(negedge clk);
    chk("R1 pwr in reset", pwr, 0);
    chk("R1 rst line in reset", card_rst, 0);
    @(negedge clk); rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R1 idle after reset", pwr | clk_en | mute | early, 0);

    // --- activation order, early answer, stop ---
    write_cmd(1, 0);
    while (!pwr) @(negedge clk);
    n = 0; while (!clk_en) begin @(negedge clk); n++; end
    chk("R2 pwr to clk delay", n, DLY);
    chk("R3 reset low at clk enable", card_rst, 0);
    n = 0; while (!card_rst) begin @(negedge clk); n++; end
    chk("R3 reset hold ticks", n, RLO);
    repeat (248) @(negedge clk); io = 0;
    repeat (8) @(negedge clk);
    chk("R5 early pulse count", early_cnt, 1);
    io = 1; repeat (5) @(negedge clk); io = 0; repeat (5) @(negedge clk);
    chk("R4 later edge ignored", early_cnt + mute_cnt, 1);
    chk("R4 session reset high", card_rst, 1);
    write_cmd(0, 0);
    while (card_rst) @(negedge clk);
    n = 0; while (clk_en) begin @(negedge clk); n++; end
    chk("R9 rst low to clk off", n, DLY);
    n = 0; while (pwr) begin @(negedge clk); n++; end
    chk("R9 clk off to pwr off", n, DLY);
    io = 1; repeat (5) @(negedge clk);

    // --- late answer with half-rate ticks ---
    tick_mode = 2; e0 = early_cnt;
    write_cmd(1, 0);
    wait_rst_high();
    repeat (900) @(negedge clk); io = 0;
    repeat (8) @(negedge clk);
    chk("R5 late answer not early", early_cnt, e0);
    repeat (1400) @(negedge clk);
    chk("R4 answer ends window", card_rst, 1);
    write_cmd(1, 1);
    repeat (4) @(negedge clk);
    chk("R7 warm ignored in session", card_rst, 1);
    write_cmd(0, 0); wait_off(); io = 1; repeat (5) @(negedge clk);

    // --- no answer: cold idle, warm, mute ---
    tick_mode = 1; m0 = mute_cnt;
    write_cmd(1, 0);
    wait_rst_high();
    write_cmd(1, 1);
    repeat (3) @(negedge clk);
    chk("R7 warm ignored in cold window", card_rst, 1);
    tick_mode = 0; repeat (300) @(negedge clk);
    chk("R12 no ticks no timeout", card_rst, 1);
    tick_mode = 1; repeat (700) @(negedge clk);
    chk("R6 no mute after cold window", mute_cnt, m0);
    chk("R6 still powered reset high", pwr & card_rst, 1);
    write_cmd(1, 1);
    chk("R7 warm drives reset low", card_rst, 0);
    wait_rst_high();
    repeat (WIN + 10) @(negedge clk);
    chk("R8 mute pulse count", mute_cnt, m0 + 1);
    chk("R8 powered after mute", pwr, 1);
    @(negedge clk); force_off = 1; cmd_wr = 1; start_bit = 1;
    @(negedge clk); force_off = 0; cmd_wr = 0;
    chk("R10 reset low after force", card_rst, 0);
    repeat (30) @(negedge clk);
    chk("R10 stays off, start cleared", pwr, 0);

    // --- answer on the expiry cycle of the warm window ---
    m0 = mute_cnt; e0 = early_cnt;
    write_cmd(1, 0);
    wait_rst_high();
    repeat (WIN + 10) @(negedge clk);
    write_cmd(1, 1);
    wait_rst_high();
    repeat (WIN - 3) @(negedge clk); io = 0;
    repeat (20) @(negedge clk);
    chk("R11 answer beats expiry, no mute", mute_cnt, m0);
    chk("R11 session reset high", card_rst, 1);
    chk("R11 no early", early_cnt, e0);
    write_cmd(0, 0); wait_off(); io = 1;
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule